// File: doc/BRIEF.md
# Two-Channel Interrupt Vector Arbiter

This block keeps the interrupt bookkeeping for a serial controller with two channels, A and B, that share one interrupt line. Each channel has a receive source and a transmit source. For each source the block holds a pending flag and an in-service flag. Within a channel, receive and transmit can never be in service at the same time. The block drives an encoded vector byte, which names the source that was posted most recently, and a pending byte that shows every source still outstanding.

Character traffic reaches the block only as single-cycle pulses: a character arrived, software read the data register, or software wrote the data register. Two software commands act on a channel's interrupts: clear-transmit-interrupt, and reset-highest-in-service. When one source of a channel is cleared while the other source of that channel is still pending, the block re-posts the other source as in service. A master control input chooses where the status code sits in the vector byte. The interrupt output is the OR, over both channels, of each channel's enabled transmit, receive and break conditions.

Top module: `twin_irq_vector`

## Requirements
- R1: While `rstN` is low, the outputs are `vector` = 0x00, `pending` = 0x00 and `rxReady` = 00. With both break inputs low, `irq` is 0.
- R2: The `pending` byte has a fixed layout. Bit 5 is receive A, bit 4 is transmit A, bit 2 is receive B and bit 1 is transmit B. Bits 7, 6, 3 and 0 always read 0. All registered outputs update on the rising edge that samples the event.
- R3: When `statusHigh` is 0 at the moment a code is written, the vector codes are: receive A 0x0C, transmit A 0x08, receive B 0x04, transmit B 0x00, and no interrupt 0x06.
- R4: When `statusHigh` is 1 at the moment a code is written, the vector codes are: receive A 0x30, transmit A 0x10, receive B 0x20, transmit B 0x00, and no interrupt 0x60. The 3-bit status code is bit-reversed and placed in bits 6:4 instead of bits 3:1.
- R5: A new receive request always sets its pending bit. It takes service and writes the vector only if that channel's transmit source is not in service. A new transmit request follows the same rule with the roles of receive and transmit swapped. The two channels do not block each other.
- R6: Clearing a source drops its pending and in-service flags and writes the no-interrupt code. If the other source of the same channel is still pending, that source then becomes in service and its code replaces the no-interrupt code.
- R7: Channel commands take effect only while the channel's `cmdValid` bit is high. Code 101 clears the transmit source. Code 111 clears the receive source if it is in service, otherwise the transmit source if that is in service. Any other code has no effect.
- R8: A `rxEvent` pulse sets `rxReady` and posts a receive request. A `dataRead` pulse clears `rxReady` and clears the receive source. A `txWrite` pulse posts a transmit request.
- R9: `irq` is 1 when any channel meets at least one of these conditions:
  - its `txIntEnable` bit is 1 and its transmit source is pending;
  - its `rxIntMode` field is 01 or 10 and its receive source is pending;
  - its `breakIntEnable` and `breakSeen` bits are both 1.
  `rxIntMode` values 00 and 11 leave receive interrupts disabled. The break term is combinational.
- R10: Events in the same cycle are applied in this order: all clears (the command first, then the data read), then receive A, receive B, transmit A, transmit B. As a result, when a receive request and a transmit request reach one channel together, the receive code is posted and the transmit source stays pending but is not in service.
- R11: For every per-channel port, index 0 is channel A and index 1 is channel B. `cmdCode[2:0]` belongs to channel A and `cmdCode[5:3]` to channel B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| statusHigh | input | 1 | Selects status code placement in bits 6:4 (1) or bits 3:1 (0) |
| rxIntMode | input | 4 | Receive interrupt mode, two bits per channel |
| txIntEnable | input | 2 | Transmit interrupt enable per channel |
| breakIntEnable | input | 2 | Break interrupt enable per channel |
| breakSeen | input | 2 | Break condition status per channel |
| rxEvent | input | 2 | Character-received pulse per channel |
| txWrite | input | 2 | Data-register write pulse per channel |
| dataRead | input | 2 | Data-register read pulse per channel |
| cmdValid | input | 2 | Command strobe per channel |
| cmdCode | input | 6 | Command field, three bits per channel |
| vector | output | 8 | Encoded interrupt vector |
| pending | output | 8 | Pending source bits |
| rxReady | output | 2 | Receive character available per channel |
| irq | output | 1 | Shared interrupt request |

## Verification
The vector, pending byte and `rxReady` come from registers. Each of them is due one rising edge after the pulse that causes it. The bench therefore drives every pulse on a falling edge, removes it on the next falling edge, and samples shortly after that, once exactly one rising edge has passed. `irq` is combinational on the enables and on the break inputs. When only a configuration input changes, the bench samples `irq` a short delay later, with no clock edge in between. The table keeps the state from one row to the next, so deferred sources, re-posting and same-cycle ordering are each checked against hand-computed codes.

// File: rtl/twin_irq_pkg.sv
package twin_irq_pkg;
  localparam int NCH = 2;
  localparam int CMD_W = 3;
  localparam int VEC_W = 8;
  localparam int MODE_W = 2;
  localparam logic [CMD_W-1:0] CMD_CLR_TX = 3'b101;
  localparam logic [CMD_W-1:0] CMD_RESET_IUS = 3'b111;

  typedef enum logic [1:0] {SRC_NONE, SRC_RX, SRC_TX} srcKind_t;

  typedef struct packed {
    logic rxInt;
    logic txInt;
    logic rxSvc;
    logic txSvc;
  } chanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NCH-1:0] setRx;
    logic [NCH-1:0] setTx;
    logic [NCH-1:0] clrRx;
    logic [NCH-1:0] clrTx;
    logic [NCH-1:0] rdAck;
  } irqStrobe_t;

  // 3-bit status: bit2 = channel A, bit1 = receive; none = 011
  function automatic logic [VEC_W-1:0] vecCode(srcKind_t kind, logic isA, logic hi);
    logic [2:0] st;
    if (kind == SRC_NONE) st = 3'b011;
    else st = {isA, kind == SRC_RX, 1'b0};
    if (hi) vecCode = {1'b0, st[0], st[1], st[2], 4'b0000};
    else vecCode = {4'b0000, st, 1'b0};
  endfunction
endpackage

// File: rtl/twin_irq_ctrl.sv
module twin_irq_ctrl
  import twin_irq_pkg::*;
(
  input  logic [NCH-1:0]       rxEvent,
  input  logic [NCH-1:0]       txWrite,
  input  logic [NCH-1:0]       dataRead,
  input  logic [NCH-1:0]       cmdValid,
  input  logic [NCH*CMD_W-1:0] cmdCode,
  input  logic [NCH-1:0]       rxSvc,
  input  logic [NCH-1:0]       txSvc,
  output irqStrobe_t           strobe
);
  logic [NCH-1:0] isClrTx;
  logic [NCH-1:0] isIus;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign isClrTx[c] = cmdValid[c] && (cmdCode[c*CMD_W +: CMD_W] == CMD_CLR_TX);
    assign isIus[c]   = cmdValid[c] && (cmdCode[c*CMD_W +: CMD_W] == CMD_RESET_IUS);
    assign strobe.clrRx[c] = dataRead[c] | (isIus[c] & rxSvc[c]);
    assign strobe.clrTx[c] = isClrTx[c] | (isIus[c] & ~rxSvc[c] & txSvc[c]);
  end

  assign strobe.setRx = rxEvent;
  assign strobe.setTx = txWrite;
  assign strobe.rdAck = dataRead;
endmodule

// File: rtl/twin_irq_datapath.sv
module twin_irq_datapath
  import twin_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  irqStrobe_t            strobe,
  input  logic                  statusHigh,
  input  logic [NCH*MODE_W-1:0] rxIntMode,
  input  logic [NCH-1:0]        txIntEnable,
  input  logic [NCH-1:0]        breakIntEnable,
  input  logic [NCH-1:0]        breakSeen,
  output logic [NCH-1:0]        rxSvc,
  output logic [NCH-1:0]        txSvc,
  output logic [VEC_W-1:0]      vector,
  output logic [VEC_W-1:0]      pending,
  output logic [NCH-1:0]        rxReady,
  output logic                  irq
);
  chanState_t       st    [NCH];
  chanState_t       nxtSt [NCH];
  logic [VEC_W-1:0] vecReg, nxtVec;
  logic [NCH-1:0]   rdyReg, nxtRdy;
  logic [NCH-1:0]   chanIrq;

  always_comb begin
    nxtSt  = st;
    nxtVec = vecReg;
    nxtRdy = rdyReg;
    // clears first, with re-post of the deferred source
    for (int c = 0; c < NCH; c++) begin
      if (strobe.clrTx[c]) begin
        nxtSt[c].txInt = 1'b0;
        nxtSt[c].txSvc = 1'b0;
        nxtVec = vecCode(SRC_NONE, c == 0, statusHigh);
        if (nxtSt[c].rxInt) begin
          nxtSt[c].rxSvc = 1'b1;
          nxtVec = vecCode(SRC_RX, c == 0, statusHigh);
        end
      end
      if (strobe.clrRx[c]) begin
        nxtSt[c].rxInt = 1'b0;
        nxtSt[c].rxSvc = 1'b0;
        nxtVec = vecCode(SRC_NONE, c == 0, statusHigh);
        if (nxtSt[c].txInt) begin
          nxtSt[c].txSvc = 1'b1;
          nxtVec = vecCode(SRC_TX, c == 0, statusHigh);
        end
      end
      if (strobe.rdAck[c]) nxtRdy[c] = 1'b0;
    end
    // receive requests before transmit requests
    for (int c = 0; c < NCH; c++) begin
      if (strobe.setRx[c]) begin
        nxtSt[c].rxInt = 1'b1;
        nxtRdy[c] = 1'b1;
        if (!nxtSt[c].txSvc) begin
          nxtSt[c].rxSvc = 1'b1;
          nxtVec = vecCode(SRC_RX, c == 0, statusHigh);
        end
      end
    end
    for (int c = 0; c < NCH; c++) begin
      if (strobe.setTx[c]) begin
        nxtSt[c].txInt = 1'b1;
        if (!nxtSt[c].rxSvc) begin
          nxtSt[c].txSvc = 1'b1;
          nxtVec = vecCode(SRC_TX, c == 0, statusHigh);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) st[c] <= '0;
      vecReg <= '0;
      rdyReg <= '0;
    end else begin
      st     <= nxtSt;
      vecReg <= nxtVec;
      rdyReg <= nxtRdy;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_out
    logic rxEn;
    assign rxEn = (rxIntMode[c*MODE_W +: MODE_W] == 2'b01) ||
                  (rxIntMode[c*MODE_W +: MODE_W] == 2'b10);
    assign chanIrq[c] = (txIntEnable[c] & st[c].txInt) | (rxEn & st[c].rxInt) |
                        (breakIntEnable[c] & breakSeen[c]);
    assign rxSvc[c] = st[c].rxSvc;
    assign txSvc[c] = st[c].txSvc;
  end

  assign pending = {2'b00, st[0].rxInt, st[0].txInt, 1'b0, st[1].rxInt, st[1].txInt, 1'b0};
  assign vector  = vecReg;
  assign rxReady = rdyReg;
  assign irq     = |chanIrq;
endmodule

// File: rtl/twin_irq_vector.sv
module twin_irq_vector
  import twin_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  statusHigh,
  input  logic [NCH*MODE_W-1:0] rxIntMode,
  input  logic [NCH-1:0]        txIntEnable,
  input  logic [NCH-1:0]        breakIntEnable,
  input  logic [NCH-1:0]        breakSeen,
  input  logic [NCH-1:0]        rxEvent,
  input  logic [NCH-1:0]        txWrite,
  input  logic [NCH-1:0]        dataRead,
  input  logic [NCH-1:0]        cmdValid,
  input  logic [NCH*CMD_W-1:0]  cmdCode,
  output logic [VEC_W-1:0]      vector,
  output logic [VEC_W-1:0]      pending,
  output logic [NCH-1:0]        rxReady,
  output logic                  irq
);
  irqStrobe_t     strobe;
  logic [NCH-1:0] rxSvc, txSvc;

  twin_irq_ctrl u_ctrl (
    .rxEvent(rxEvent), .txWrite(txWrite), .dataRead(dataRead),
    .cmdValid(cmdValid), .cmdCode(cmdCode),
    .rxSvc(rxSvc), .txSvc(txSvc), .strobe(strobe)
  );

  twin_irq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusHigh(statusHigh),
    .rxIntMode(rxIntMode), .txIntEnable(txIntEnable),
    .breakIntEnable(breakIntEnable), .breakSeen(breakSeen),
    .rxSvc(rxSvc), .txSvc(txSvc), .vector(vector), .pending(pending),
    .rxReady(rxReady), .irq(irq)
  );
endmodule

// File: rtl/twin_irq_checker.sv
module twin_irq_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] txIntEnable,
  input logic [1:0] rxEvent,
  input logic [1:0] txWrite,
  input logic [1:0] dataRead,
  input logic [1:0] cmdValid,
  input logic [5:0] cmdCode,
  input logic [7:0] pending,
  input logic [1:0] rxReady,
  input logic       irq
);
  assert_read_clears_rx_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead[0] && !rxEvent[0]) |=> (!pending[5] && !rxReady[0]));

  assert_rx_event_posts_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxEvent[1] |=> (pending[2] && rxReady[1]));

  assert_write_posts_tx_R8: assert property (@(posedge clk) disable iff (!rstN)
    txWrite[1] |=> pending[1]);

  assert_cmd_clears_tx_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid[0] && cmdCode[2:0] == 3'b101 && !txWrite[0]) |=> !pending[4]);

  assert_tx_raises_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txIntEnable[0] && pending[4]) |-> irq);
endmodule

bind twin_irq_vector twin_irq_checker u_chk (
  .clk(clk), .rstN(rstN), .txIntEnable(txIntEnable), .rxEvent(rxEvent),
  .txWrite(txWrite), .dataRead(dataRead), .cmdValid(cmdValid),
  .cmdCode(cmdCode), .pending(pending), .rxReady(rxReady), .irq(irq)
);

// File: tb/twin_irq_vector_bench.sv
module twin_irq_vector_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic statusHigh = 1'b0;
  logic [3:0] rxIntMode = 4'b1001;
  logic [1:0] txIntEnable = 2'b11;
  logic [1:0] breakIntEnable = 2'b00;
  logic [1:0] breakSeen = 2'b00;
  logic [1:0] rxEvent = '0, txWrite = '0, dataRead = '0, cmdValid = '0;
  logic [5:0] cmdCode = '0;
  logic [7:0] vector, pending;
  logic [1:0] rxReady;
  logic irq;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  twin_irq_vector u_twin_irq_vector (
    .clk(clk), .rstN(rstN), .statusHigh(statusHigh), .rxIntMode(rxIntMode),
    .txIntEnable(txIntEnable), .breakIntEnable(breakIntEnable),
    .breakSeen(breakSeen), .rxEvent(rxEvent), .txWrite(txWrite),
    .dataRead(dataRead), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .vector(vector), .pending(pending), .rxReady(rxReady), .irq(irq)
  );

  typedef struct packed {
    logic hi;
    logic [1:0] rx, tx, rd, cv;
    logic [5:0] cmd;
    logic [7:0] eVec, ePend;
    logic [1:0] eRdy;
    logic eIrq;
  } step_t;

  localparam int NSTEP = 20;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b0, 2'b01, 2'b00, 2'b00, 2'b00, 6'o00, 8'h0C, 8'h20, 2'b01, 1'b1}, // R3 rx A
    '{1'b0, 2'b00, 2'b01, 2'b00, 2'b00, 6'o00, 8'h0C, 8'h30, 2'b01, 1'b1}, // R5 tx A deferred
    '{1'b0, 2'b00, 2'b00, 2'b00, 2'b01, 6'o07, 8'h08, 8'h10, 2'b01, 1'b1}, // R6 R7 IUS re-posts tx
    '{1'b0, 2'b00, 2'b00, 2'b00, 2'b01, 6'o05, 8'h06, 8'h00, 2'b01, 1'b0}, // R7 clear tx
    '{1'b0, 2'b10, 2'b00, 2'b00, 2'b00, 6'o00, 8'h04, 8'h04, 2'b11, 1'b1}, // R3 R11 rx B
    '{1'b0, 2'b00, 2'b10, 2'b00, 2'b00, 6'o00, 8'h04, 8'h06, 2'b11, 1'b1}, // R5 tx B deferred
    '{1'b0, 2'b00, 2'b00, 2'b10, 2'b00, 6'o00, 8'h00, 8'h02, 2'b01, 1'b1}, // R8 R6 read B
    '{1'b0, 2'b00, 2'b00, 2'b00, 2'b10, 6'o70, 8'h06, 8'h00, 2'b01, 1'b0}, // R7 IUS clears tx B
    '{1'b0, 2'b01, 2'b01, 2'b00, 2'b00, 6'o00, 8'h0C, 8'h30, 2'b01, 1'b1}, // R10 same cycle
    '{1'b0, 2'b00, 2'b00, 2'b00, 2'b01, 6'o02, 8'h0C, 8'h30, 2'b01, 1'b1}, // R7 other code
    '{1'b0, 2'b00, 2'b00, 2'b01, 2'b00, 6'o00, 8'h08, 8'h10, 2'b00, 1'b1}, // R8 read A
    '{1'b1, 2'b00, 2'b00, 2'b00, 2'b01, 6'o05, 8'h60, 8'h00, 2'b00, 1'b0}, // R4 none high
    '{1'b1, 2'b00, 2'b10, 2'b00, 2'b00, 6'o00, 8'h00, 8'h02, 2'b00, 1'b1}, // R4 tx B
    '{1'b1, 2'b01, 2'b00, 2'b00, 2'b00, 6'o00, 8'h30, 8'h22, 2'b01, 1'b1}, // R4 R5 cross channel
    '{1'b1, 2'b10, 2'b00, 2'b00, 2'b00, 6'o00, 8'h30, 8'h26, 2'b11, 1'b1}, // R5 rx B blocked
    '{1'b1, 2'b00, 2'b00, 2'b00, 2'b10, 6'o70, 8'h20, 8'h24, 2'b11, 1'b1}, // R6 re-post rx B
    '{1'b1, 2'b00, 2'b00, 2'b01, 2'b00, 6'o00, 8'h60, 8'h04, 2'b10, 1'b1}, // R8 read A
    '{1'b1, 2'b00, 2'b00, 2'b10, 2'b00, 6'o00, 8'h60, 8'h00, 2'b00, 1'b0}, // R8 read B
    '{1'b1, 2'b00, 2'b01, 2'b00, 2'b00, 6'o00, 8'h10, 8'h10, 2'b00, 1'b1}, // R4 tx A
    '{1'b0, 2'b00, 2'b00, 2'b00, 2'b01, 6'o07, 8'h06, 8'h00, 2'b00, 1'b0}  // R7 IUS tx A
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [1:0] rx, logic [1:0] tx, logic [1:0] rd,
                       logic [1:0] cv, logic [5:0] cmd);
    @(negedge clk);
    rxEvent = rx; txWrite = tx; dataRead = rd; cmdValid = cv; cmdCode = cmd;
    @(negedge clk);
    rxEvent = '0; txWrite = '0; dataRead = '0; cmdValid = '0; cmdCode = '0;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 vector in reset", vector, 8'h00);
    check("R1 pending in reset", pending, 8'h00);
    check("R1 rxReady in reset", {6'b0, rxReady}, 8'h00);
    check("R1 irq in reset", {7'b0, irq}, 8'h00);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NSTEP; i++) begin
      statusHigh = STEPS[i].hi;
      pulse(STEPS[i].rx, STEPS[i].tx, STEPS[i].rd, STEPS[i].cv, STEPS[i].cmd);
      check($sformatf("R2-R8 step %0d vector", i), vector, STEPS[i].eVec);
      check($sformatf("R2 step %0d pending", i), pending, STEPS[i].ePend);
      check($sformatf("R8 step %0d rxReady", i), {6'b0, rxReady}, {6'b0, STEPS[i].eRdy});
      check($sformatf("R9 step %0d irq", i), {7'b0, irq}, {7'b0, STEPS[i].eIrq});
    end

    // R9 transmit enable gating
    txIntEnable = 2'b00;
    pulse(2'b00, 2'b01, 2'b00, 2'b00, 6'o00);
    check("R9 tx pending while disabled", pending, 8'h10);
    check("R9 irq off with tx disabled", {7'b0, irq}, 8'h00);
    @(negedge clk) txIntEnable = 2'b01; #1;
    check("R9 irq on after tx enable", {7'b0, irq}, 8'h01);
    pulse(2'b00, 2'b00, 2'b00, 2'b01, 6'o05);
    check("R7 tx A cleared", pending, 8'h00);

    // R9 receive mode 11 does not enable
    rxIntMode = 4'b1011;
    pulse(2'b01, 2'b00, 2'b00, 2'b00, 6'o00);
    check("R9 rx pending mode 11", pending, 8'h20);
    check("R9 irq off mode 11", {7'b0, irq}, 8'h00);
    @(negedge clk) rxIntMode = 4'b1001; #1;
    check("R9 irq on mode 01", {7'b0, irq}, 8'h01);
    pulse(2'b00, 2'b00, 2'b01, 2'b00, 6'o00);
    check("R8 read clears rx A", pending, 8'h00);
    check("R8 read clears rxReady", {6'b0, rxReady}, 8'h00);

    // R9 break term on channel B
    @(negedge clk) breakIntEnable = 2'b10; #1;
    check("R9 break enable alone", {7'b0, irq}, 8'h00);
    @(negedge clk) breakSeen = 2'b10; #1;
    check("R9 break enabled and seen", {7'b0, irq}, 8'h01);
    @(negedge clk) breakIntEnable = 2'b00; #1;
    check("R9 break seen but disabled", {7'b0, irq}, 8'h00);
    @(negedge clk) breakSeen = 2'b00;

    // R1 reset in mid-run
    pulse(2'b10, 2'b00, 2'b00, 2'b00, 6'o00);
    check("R11 rx B before reset", pending, 8'h04);
    @(negedge clk) rstN = 1'b0; #1;
    check("R1 pending after reset", pending, 8'h00);
    check("R1 rxReady after reset", {6'b0, rxReady}, 8'h00);
    check("R1 vector after reset", vector, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule